// File: doc/BRIEF.md
# System Exception Pending Register

This block holds the pending state of three system exceptions (non-maskable interrupt, deferred service call and periodic timer tick) behind one 32-bit control/status word. Software sets or clears each pending flag by writing the word. Set and clear bits come in pairs, and when both bits of a pair are written together the set wins. The non-maskable flag has a set bit only, so software cannot withdraw it.

A read returns the three pending flags together with status fields that the surrounding interrupt logic supplies. These fields are the number of the vector now being serviced, the highest pending vector number, and two summary flags for the external interrupt lines. The three pending flags also leave the block as plain outputs for a priority arbiter elsewhere. A hardware set input lets the tick timer raise its flag. An acknowledge input, carrying the vector number of the exception being taken, clears the matching flag.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is used. A write is sampled on a clock edge and shows on the outputs after that edge. The read word is combinational from the registered flags and the current status inputs.

Top module: `syspend_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, all three pending outputs are 0 and read bits 31, 28 and 26 are 0.
- R2: A write with bit 31 = 1 makes the non-maskable flag 1 after the next edge. Writing bit 31 = 0 leaves it unchanged, and no written value clears it.
- R3: A write with bit 28 = 1 sets the deferred-service flag. Bit 27 = 1 clears it only when bit 28 is 0 in the same write.
- R4: A write with bit 26 = 1 sets the tick flag. Bit 25 = 1 clears it only when bit 26 is 0 in the same write.
- R5: `tick_set` = 1 sets the tick flag at the next edge, even when a software clear (bit 25) or an acknowledge of the tick vector arrives in the same cycle.
- R6: `ack_valid` with `ack_vec` equal to 2 (non-maskable), 14 (deferred service) or 15 (tick) clears that flag unless the same flag is being set in the same cycle. An acknowledge of any other vector changes nothing.
- R7: Read bit 31 is the non-maskable flag, bit 28 the deferred-service flag and bit 26 the tick flag. Bits 30, 29, 27, 25, 24, 23, 21, 10 and 9 read 0.
- R8: Read bits [8:0] equal `act_vec` when `act_valid` is 1 and read 0 otherwise.
- R9: Read bits [20:12] equal `pend_vec` when `pend_valid` is 1 and read 0 otherwise.
- R10: Read bit 22 equals `ext_pend_any` and read bit 11 equals `ext_other_act`.
- R11: A write changes nothing until the next rising edge. The read word in the cycle of the write still shows the previous flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Written control word |
| rd_data | output | 32 | Read word: flags and status fields |
| tick_set | input | 1 | Hardware request to set the tick flag |
| ack_valid | input | 1 | Exception-taken strobe |
| ack_vec | input | 9 | Vector number of the exception taken |
| act_valid | input | 1 | An exception is being serviced |
| act_vec | input | 9 | Vector number being serviced |
| pend_valid | input | 1 | A pending vector exists |
| pend_vec | input | 9 | Highest pending vector number |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| ext_other_act | input | 1 | An external interrupt other than the serviced one is active |
| nmi_pend | output | 1 | Non-maskable exception pending |
| svc_pend | output | 1 | Deferred-service exception pending |
| tick_pend | output | 1 | Tick exception pending |

## Verification
The only state is the three flags. A wrong flag shows at once on its dedicated output and in its read bit, in the cycle after the write, tick request or acknowledge that produced it. A mistake in the set-over-clear priority or in the acknowledge decode therefore appears one edge after the faulty stimulus. A mis-packed status field needs no state to show: it appears in the same cycle on the read word, so the read word is compared in every cycle against a model while the status inputs vary.

// File: rtl/syspend_pkg.sv
package syspend_pkg;
  localparam int N_EXC = 3;
  localparam int WORD_W = 32;

  // Flag index of each exception
  localparam int IDX_NMI = 0;
  localparam int IDX_SVC = 1;
  localparam int IDX_TICK = 2;

  // Write-side bit positions; -1 marks "no clear bit"
  localparam int SET_POS [N_EXC] = '{31, 28, 26};
  localparam int CLR_POS [N_EXC] = '{-1, 27, 25};

  // Read-side field positions
  localparam int RD_ACT_LSB = 0;
  localparam int RD_PEND_LSB = 12;
  localparam int RD_OTHER_ACT = 11;
  localparam int RD_EXT_PEND = 22;
endpackage

// File: rtl/syspend_wr_decode.sv
module syspend_wr_decode
  import syspend_pkg::*;
(
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [N_EXC-1:0]  set_sw,
  output logic [N_EXC-1:0]  clr_sw
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  for (genvar i = 0; i < N_EXC; i++) begin : g_dec
    assign set_sw[i] = wr_en & wr_data[SET_POS[i]];
    if (CLR_POS[i] >= 0) begin : g_clr
      assign clr_sw[i] = wr_en & wr_data[CLR_POS[i]];
    end else begin : g_noclr
      assign clr_sw[i] = 1'b0;
    end
  end
endmodule

// File: rtl/syspend_flag.sv
module syspend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // Set has priority over any clear source
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  assert_clear_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
  // Without a request the flag holds its value
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/syspend_rd_pack.sv
module syspend_rd_pack
  import syspend_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic [N_EXC-1:0]  flags,
  input  logic              act_valid,
  input  logic [VEC_W-1:0]  act_vec,
  input  logic              pend_valid,
  input  logic [VEC_W-1:0]  pend_vec,
  input  logic              ext_pend_any,
  input  logic              ext_other_act,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    rd_data[RD_ACT_LSB +: VEC_W]  = act_valid  ? act_vec  : '0;
    rd_data[RD_PEND_LSB +: VEC_W] = pend_valid ? pend_vec : '0;
    rd_data[RD_OTHER_ACT] = ext_other_act;
    rd_data[RD_EXT_PEND]  = ext_pend_any;
    for (int i = 0; i < N_EXC; i++) begin
      rd_data[SET_POS[i]] = flags[i];
    end
  end
endmodule

// File: rtl/syspend_ctrl.sv
module syspend_ctrl
  import syspend_pkg::*;
#(
  parameter int VEC_W    = 9,
  parameter int NMI_VEC  = 2,
  parameter int SVC_VEC  = 14,
  parameter int TICK_VEC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              tick_set,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  input  logic              act_valid,
  input  logic [VEC_W-1:0]  act_vec,
  input  logic              pend_valid,
  input  logic [VEC_W-1:0]  pend_vec,
  input  logic              ext_pend_any,
  input  logic              ext_other_act,
  output logic              nmi_pend,
  output logic              svc_pend,
  output logic              tick_pend
);
  localparam int EXC_VEC [N_EXC] = '{NMI_VEC, SVC_VEC, TICK_VEC};

  logic [N_EXC-1:0] set_sw, clr_sw, ack_hit, hw_set, flags;

  syspend_wr_decode u_dec (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .set_sw (set_sw),
    .clr_sw (clr_sw)
  );

  for (genvar i = 0; i < N_EXC; i++) begin : g_flag
    assign ack_hit[i] = ack_valid && (ack_vec == VEC_W'(EXC_VEC[i]));
    if (i == IDX_TICK) begin : g_hw
      assign hw_set[i] = tick_set;
    end else begin : g_nohw
      assign hw_set[i] = 1'b0;
    end
    syspend_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_sw[i] | hw_set[i]),
      .clr_i(clr_sw[i] | ack_hit[i]),
      .q    (flags[i])
    );
  end

  syspend_rd_pack #(.VEC_W(VEC_W)) u_pack (
    .flags        (flags),
    .act_valid    (act_valid),
    .act_vec      (act_vec),
    .pend_valid   (pend_valid),
    .pend_vec     (pend_vec),
    .ext_pend_any (ext_pend_any),
    .ext_other_act(ext_other_act),
    .rd_data      (rd_data)
  );

  assign nmi_pend  = flags[IDX_NMI];
  assign svc_pend  = flags[IDX_SVC];
  assign tick_pend = flags[IDX_TICK];

  // Port-level checks
  assert_nmi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31]) |=> nmi_pend);
  assert_nmi_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !(ack_valid && ack_vec == VEC_W'(NMI_VEC))) |=> nmi_pend);
  assert_svc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[28]) |=> svc_pend);
  assert_tick_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[26]) |=> tick_pend);
  assert_hw_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_set |=> tick_pend);
  assert_rd_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] == nmi_pend) && (rd_data[28] == svc_pend) && (rd_data[26] == tick_pend));
endmodule

// File: tb/syspend_ctrl_tb.sv
`timescale 1ns/1ps
module syspend_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_set = 1'b0;
  logic        ack_valid = 1'b0;
  logic [8:0]  ack_vec = '0;
  logic        act_valid = 1'b0;
  logic [8:0]  act_vec = '0;
  logic        pend_valid = 1'b0;
  logic [8:0]  pend_vec = '0;
  logic        ext_pend_any = 1'b0;
  logic        ext_other_act = 1'b0;
  logic        nmi_pend, svc_pend, tick_pend;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  syspend_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_set(tick_set), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .act_valid(act_valid), .act_vec(act_vec), .pend_valid(pend_valid), .pend_vec(pend_vec),
    .ext_pend_any(ext_pend_any), .ext_other_act(ext_other_act),
    .nmi_pend(nmi_pend), .svc_pend(svc_pend), .tick_pend(tick_pend)
  );

  // Behavioural reference model
  logic m_nmi, m_svc, m_tick;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nmi <= 0; m_svc <= 0; m_tick <= 0;
    end else begin
      if (wr_en && wr_data[31]) m_nmi <= 1;
      else if (ack_valid && ack_vec == 2) m_nmi <= 0;
      if (wr_en && wr_data[28]) m_svc <= 1;
      else if ((wr_en && wr_data[27]) || (ack_valid && ack_vec == 14)) m_svc <= 0;
      if ((wr_en && wr_data[26]) || tick_set) m_tick <= 1;
      else if ((wr_en && wr_data[25]) || (ack_valid && ack_vec == 15)) m_tick <= 0;
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[31] = m_nmi;
    v[28] = m_svc;
    v[26] = m_tick;
    v[22] = ext_pend_any;
    v[20:12] = pend_valid ? pend_vec : 9'd0;
    v[11] = ext_other_act;
    v[8:0] = act_valid ? act_vec : 9'd0;
    return v;
  endfunction

  task automatic check(input string tag);
    logic [34:0] act, exp;
    act = {nmi_pend, svc_pend, tick_pend, rd_data};
    exp = {m_nmi, m_svc, m_tick, exp_rd()};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual flags=%b rd=%h expected flags=%b rd=%h",
               tag, act[34:32], act[31:0], exp[34:32], exp[31:0]);
    end
  endtask

  // Drive after a falling edge, check before and after the next rising edge
  task automatic step(input string tag, input logic we, input logic [31:0] d,
                      input logic tk, input logic av, input logic [8:0] avec);
    wr_en = we; wr_data = d; tick_set = tk; ack_valid = av; ack_vec = avec;
    #1 check("R11");
    @(negedge clk);
    wr_en = 0; wr_data = '0; tick_set = 0; ack_valid = 0; ack_vec = '0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
    // R2: non-maskable set, zero write, no software clear
    step("R2", 1, 32'h8000_0000, 0, 0, 0);
    step("R2", 1, 32'h7FFF_FFFF, 0, 0, 0);
    // R3: deferred-service pair
    step("R3", 1, 32'h1000_0000, 0, 0, 0);
    step("R3", 1, 32'h1800_0000, 0, 0, 0);
    step("R3", 1, 32'h0800_0000, 0, 0, 0);
    step("R3", 1, 32'h0800_0000, 0, 0, 0);
    // R4: tick pair
    step("R4", 1, 32'h0400_0000, 0, 0, 0);
    step("R4", 1, 32'h0200_0000, 0, 0, 0);
    step("R4", 1, 32'h0600_0000, 0, 0, 0);
    step("R4", 1, 32'h0200_0000, 0, 0, 0);
    // R5: hardware set against software clear and acknowledge
    step("R5", 1, 32'h0200_0000, 1, 0, 0);
    step("R5", 0, 32'h0, 1, 1, 9'd15);
    // R6: acknowledge decoding
    step("R6", 1, 32'h1000_0000, 0, 0, 0);
    step("R6", 0, 32'h0, 0, 1, 9'd7);
    step("R6", 0, 32'h0, 0, 1, 9'd14);
    step("R6", 0, 32'h0, 0, 1, 9'd15);
    step("R6", 1, 32'h8000_0000, 0, 1, 9'd2);
    step("R6", 0, 32'h0, 0, 1, 9'd2);
    // R7: flags and reserved bits with everything set
    step("R7", 1, 32'hFFFF_FFFF, 1, 0, 0);
    // R8 / R9 / R10: status fields
    act_vec = 9'h1A5; pend_vec = 9'h0C3; act_valid = 0; pend_valid = 0;
    #1 check("R8");
    act_valid = 1;
    #1 check("R8");
    pend_valid = 1;
    #1 check("R9");
    pend_valid = 0;
    #1 check("R9");
    ext_pend_any = 1;
    #1 check("R10");
    ext_other_act = 1; ext_pend_any = 0;
    #1 check("R10");
    @(negedge clk);
    // Random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      wr_en = ($urandom % 3) == 0;
      wr_data = $urandom;
      tick_set = ($urandom % 5) == 0;
      ack_valid = ($urandom % 3) == 0;
      ack_vec = (($urandom % 2) == 0) ? 9'($urandom) : 9'(((($urandom % 3) == 0) ? 2 : 14) + ($urandom % 2));
      act_valid = $urandom; act_vec = $urandom;
      pend_valid = $urandom; pend_vec = $urandom;
      ext_pend_any = $urandom; ext_other_act = $urandom;
      #1 check("R11");
      @(negedge clk);
      check("R7");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule